// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This unit performs the single-byte rotate, shift, nibble-exchange and bit-test operations of an 8-bit processor datapath. It also performs the four fast accumulator rotates. It receives an operand byte, the current carry flag, a 4-bit operation code and a 3-bit bit index. From these it forms a result byte, a write-back enable and the four new condition flags: zero, subtract, half-carry and carry.

The arithmetic is purely combinational. A single register stage captures the result and the flags on a rising clock edge when `en` is high and the operation code is a defined one. Otherwise the outputs keep their previous values. The surrounding datapath chooses where the operand comes from and where the result goes. It uses `wb_q` to decide whether the destination is written.

Top module: `rsb_unit`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first capture, every output is 0.
- R2: When `en` is low at a rising edge, every output keeps its value.
- R3: Circular rotates: code 0 (left) gives `{d[6:0],d[7]}` with C=d[7]. Code 1 (right) gives `{d[0],d[7:1]}` with C=d[0].
- R4: Rotates through carry: code 2 (left) gives `{d[6:0],cin}` with C=d[7]. Code 3 (right) gives `{cin,d[7:1]}` with C=d[0].
- R5: Shifts: code 4 (left arithmetic) gives `{d[6:0],0}` with C=d[7]. Code 5 (right arithmetic) gives `{d[7],d[7:1]}` with C=d[0]. Code 6 (right logical) gives `{0,d[7:1]}` with C=d[0].
- R6: For codes 0 to 7, Z is 1 exactly when the result is zero, N and H are 0, and `wb_q` is 1.
- R7: Code 7 exchanges the nibbles, giving `{d[3:0],d[7:4]}`, and clears C.
- R8: Code 8 tests a bit. Z is the inverse of `d[bit_sel]`, N is 0, H is 1, C equals `cin`, `wb_q` is 0, and the result equals the operand unchanged.
- R9: Accumulator rotates use codes 9 (circular left), 10 (circular right), 11 (left through carry) and 12 (right through carry). They give the same result and C as codes 0 to 3. Z, N and H are always 0, and `wb_q` is 1.
- R10: Codes 13 to 15 are reserved. With `en` high they leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture enable |
| op_sel | input | 4 | Operation code (see R3 to R10) |
| operand | input | 8 | Operand byte |
| carry_in | input | 1 | Current carry flag |
| bit_sel | input | 3 | Bit index for the bit test, 0 to 7 |
| result_q | output | 8 | Registered result byte |
| wb_q | output | 1 | Registered write-back enable |
| z_q | output | 1 | Registered zero flag |
| n_q | output | 1 | Registered subtract flag |
| h_q | output | 1 | Registered half-carry flag |
| c_q | output | 1 | Registered carry flag |

## Verification
The assertions assume that the inputs are known, two-state values that are stable around each rising edge. They also assume that the reserved codes 13 to 15 may appear at any time and must do nothing. The stimulus changes every input only on the falling edge. It draws operation codes from the full 4-bit range, so reserved codes and idle cycles occur often, and it uses fully random operand bytes, carry and bit index. Directed cases add all-zero and all-one operands, a lone carry bit rotating through zero, and the bit test at indices 0 and 7.

// File: rtl/rsb_unit.sv
module rsb_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] operand,
  input  logic         carry_in,
  input  logic [2:0]   bit_sel,
  output logic [W-1:0] result_q,
  output logic         wb_q,
  output logic         z_q,
  output logic         n_q,
  output logic         h_q,
  output logic         c_q
);
  localparam int H = W / 2;

  localparam logic [3:0] OP_RLC  = 4'd0;
  localparam logic [3:0] OP_RRC  = 4'd1;
  localparam logic [3:0] OP_RL   = 4'd2;
  localparam logic [3:0] OP_RR   = 4'd3;
  localparam logic [3:0] OP_SLA  = 4'd4;
  localparam logic [3:0] OP_SRA  = 4'd5;
  localparam logic [3:0] OP_SRL  = 4'd6;
  localparam logic [3:0] OP_SWAP = 4'd7;
  localparam logic [3:0] OP_BIT  = 4'd8;
  localparam logic [3:0] OP_ARLC = 4'd9;
  localparam logic [3:0] OP_ARRC = 4'd10;
  localparam logic [3:0] OP_ARL  = 4'd11;
  localparam logic [3:0] OP_ARR  = 4'd12;

  logic [W-1:0] res;
  logic         cout;
  logic         known;
  logic         acc_form;
  logic         is_bit;
  logic         msb, lsb;

  assign msb      = operand[W-1];
  assign lsb      = operand[0];
  assign acc_form = (op_sel >= OP_ARLC) && (op_sel <= OP_ARR);
  assign is_bit   = (op_sel == OP_BIT);

  always_comb begin
    res   = operand;
    cout  = carry_in;
    known = 1'b1;
    unique case (op_sel)
      OP_RLC, OP_ARLC: begin res = {operand[W-2:0], msb};      cout = msb; end
      OP_RRC, OP_ARRC: begin res = {lsb, operand[W-1:1]};      cout = lsb; end
      OP_RL,  OP_ARL:  begin res = {operand[W-2:0], carry_in}; cout = msb; end
      OP_RR,  OP_ARR:  begin res = {carry_in, operand[W-1:1]}; cout = lsb; end
      OP_SLA:          begin res = {operand[W-2:0], 1'b0};     cout = msb; end
      OP_SRA:          begin res = {msb, operand[W-1:1]};      cout = lsb; end
      OP_SRL:          begin res = {1'b0, operand[W-1:1]};     cout = lsb; end
      OP_SWAP:         begin res = {operand[H-1:0], operand[W-1:H]}; cout = 1'b0; end
      OP_BIT:          begin res = operand;                    cout = carry_in; end
      default:         known = 1'b0;
    endcase
  end

  logic z_next;
  assign z_next = is_bit   ? ~operand[bit_sel] :
                  acc_form ? 1'b0 : (res == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      wb_q     <= 1'b0;
      z_q      <= 1'b0;
      n_q      <= 1'b0;
      h_q      <= 1'b0;
      c_q      <= 1'b0;
    end else if (en && known) begin
      result_q <= res;
      wb_q     <= ~is_bit;
      z_q      <= z_next;
      n_q      <= 1'b0;
      h_q      <= is_bit;
      c_q      <= cout;
    end
  end
endmodule

module rsb_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [3:0] op_sel,
  input logic [7:0] operand,
  input logic       carry_in,
  input logic [2:0] bit_sel,
  input logic [7:0] result_q,
  input logic       wb_q,
  input logic       z_q,
  input logic       n_q,
  input logic       h_q,
  input logic       c_q
);
  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(result_q) && $stable(wb_q) && $stable(z_q) &&
             $stable(n_q) && $stable(h_q) && $stable(c_q)));

  p_reserved_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel >= 4'd13) |=> ($stable(result_q) && $stable(wb_q) && $stable(z_q) &&
                                 $stable(n_q) && $stable(h_q) && $stable(c_q)));

  p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel <= 4'd7) |=> (z_q == (result_q == 8'd0) && !n_q && !h_q && wb_q));

  p_swap_nibbles_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel == 4'd7) |=> (result_q == {$past(operand[3:0]), $past(operand[7:4])} && !c_q));

  p_bit_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel == 4'd8) |=> (h_q && !n_q && !wb_q && c_q == $past(carry_in) &&
                                z_q == !$past(operand[bit_sel]) && result_q == $past(operand)));

  p_acc_zero_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel >= 4'd9 && op_sel <= 4'd12) |=> (!z_q && !n_q && !h_q && wb_q));

  p_rlc_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel == 4'd0) |=> (c_q == $past(operand[7]) && result_q[0] == $past(operand[7])));
endmodule

bind rsb_unit rsb_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .op_sel(op_sel), .operand(operand),
  .carry_in(carry_in), .bit_sel(bit_sel), .result_q(result_q), .wb_q(wb_q),
  .z_q(z_q), .n_q(n_q), .h_q(h_q), .c_q(c_q)
);

// File: tb/sim_rsb_unit.sv
`timescale 1ns/1ps
module sim_rsb_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] op_sel = '0;
  logic [7:0] operand = '0;
  logic       carry_in = 1'b0;
  logic [2:0] bit_sel = '0;
  logic [7:0] result_q;
  logic       wb_q, z_q, n_q, h_q, c_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [12:0] exp_st = '0; // {res, wb, z, n, h, c}

  always #2.5 clk = ~clk;

  rsb_unit u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .op_sel(op_sel), .operand(operand),
    .carry_in(carry_in), .bit_sel(bit_sel), .result_q(result_q), .wb_q(wb_q),
    .z_q(z_q), .n_q(n_q), .h_q(h_q), .c_q(c_q)
  );

  function automatic string tag(input logic e, input logic [3:0] op);
    if (!e) return "R2";
    if (op <= 4'd1) return "R3";
    if (op <= 4'd3) return "R4";
    if (op <= 4'd6) return "R5";
    if (op == 4'd7) return "R7";
    if (op == 4'd8) return "R8";
    if (op <= 4'd12) return "R9";
    return "R10";
  endfunction

  // returns {valid, res, wb, z, n, h, c}
  function automatic logic [13:0] model(input logic [3:0] op, input logic [7:0] d,
                                        input logic ci, input logic [2:0] b);
    logic [7:0] r;
    logic c;
    logic z;
    case (op)
      4'd0, 4'd9:  begin r = {d[6:0], d[7]}; c = d[7]; end
      4'd1, 4'd10: begin r = {d[0], d[7:1]}; c = d[0]; end
      4'd2, 4'd11: begin r = {d[6:0], ci};   c = d[7]; end
      4'd3, 4'd12: begin r = {ci, d[7:1]};   c = d[0]; end
      4'd4: begin r = d << 1; c = d[7]; end
      4'd5: begin r = {d[7], d[7:1]}; c = d[0]; end
      4'd6: begin r = d >> 1; c = d[0]; end
      4'd7: begin r = {d[3:0], d[7:4]}; c = 1'b0; end
      4'd8: begin r = d; c = ci; end
      default: return '0;
    endcase
    if (op == 4'd8) return {1'b1, d, 1'b0, ~d[b], 1'b0, 1'b1, ci};
    z = (op >= 4'd9) ? 1'b0 : (r == 8'd0);
    return {1'b1, r, 1'b1, z, 1'b0, 1'b0, c};
  endfunction

  task automatic compare(input string t);
    logic [12:0] got;
    got = {result_q, wb_q, z_q, n_q, h_q, c_q};
    checks++;
    if (got !== exp_st) begin
      errors++;
      $display("FAIL %s: got res=%02h wb%b z%b n%b h%b c%b, expected res=%02h wb%b z%b n%b h%b c%b",
               t, got[12:5], got[4], got[3], got[2], got[1], got[0],
               exp_st[12:5], exp_st[4], exp_st[3], exp_st[2], exp_st[1], exp_st[0]);
    end
  endtask

  task automatic step(input logic e, input logic [3:0] op, input logic [7:0] d,
                      input logic ci, input logic [2:0] b);
    logic [13:0] m;
    @(negedge clk);
    en = e; op_sel = op; operand = d; carry_in = ci; bit_sel = b;
    m = model(op, d, ci, b);
    if (e && m[13]) exp_st = m[12:0];
    @(negedge clk);
    compare(tag(e, op));
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    checks++;
    if ({result_q, wb_q, z_q, n_q, h_q, c_q} !== 13'd0) begin
      errors++;
      $display("FAIL R1: outputs %02h/%b%b%b%b%b, expected all zero",
               result_q, wb_q, z_q, n_q, h_q, c_q);
    end
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    step(1, 4'd0, 8'h80, 0, 0);  // R3 RLC 80 -> 01 C=1
    step(1, 4'd1, 8'h01, 0, 0);  // R3 RRC 01 -> 80 C=1
    step(1, 4'd2, 8'h80, 0, 0);  // R4/R6 RL 80 c0 -> 00 Z=1 C=1
    step(1, 4'd3, 8'h01, 1, 0);  // R4 RR 01 c1 -> 80 C=1
    step(1, 4'd4, 8'hFF, 0, 0);  // R5 SLA
    step(1, 4'd5, 8'h81, 0, 0);  // R5 SRA keeps msb
    step(1, 4'd6, 8'h01, 0, 0);  // R5/R6 SRL -> 00 Z=1
    step(1, 4'd7, 8'h00, 1, 0);  // R7 SWAP zero
    step(1, 4'd7, 8'hA5, 1, 0);  // R7 SWAP -> 5A
    step(1, 4'd8, 8'h7F, 1, 3'd7); // R8 bit 7 clear -> Z=1
    step(1, 4'd8, 8'h01, 0, 3'd0); // R8 bit 0 set -> Z=0
    step(1, 4'd11, 8'h80, 0, 0); // R9 RLA result zero but Z=0
    step(1, 4'd9, 8'h00, 0, 0);  // R9 zero operand, Z=0
    step(0, 4'd7, 8'h12, 1, 0);  // R2 idle hold
    step(1, 4'd13, 8'h55, 1, 0); // R10 reserved
    step(1, 4'd15, 8'hFF, 0, 0); // R10 reserved

    for (int i = 0; i < 600; i++) begin
      step($urandom_range(0, 7) != 0, 4'($urandom_range(0, 15)),
           8'($urandom), 1'($urandom), 3'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule